// File: doc/BRIEF.md
# PC Card Space Address Translator

This block sits between a host bus and a PC card socket. The host holds a small control register in the block. Three bits of that register choose the card memory space (common or attribute), give the top card address line used for common memory, and select between two address-window sizes. Each host request carries an offset inside the card window, a memory/I-O flag, a transfer size, an endianness flag, a direction and write data. The block drives the card address lines, the register-select pin, the direction and the write data. It then waits for the card to report that the cycle is complete, and returns one completion pulse with the read data.

The top address line (bit 25) carries the segment bit only for common-memory accesses. It is always low for attribute memory and for I/O. The register-select pin follows the space bit for memory accesses and is held low for every I/O access.

A 16-bit I/O access in little-endian mode, to a card that reports a byte-wide port, becomes two byte cycles:
- The even byte goes first, at the offset.
- The odd byte follows at the offset plus one.
- Both bytes travel on the low data lane.
- The two halves are merged into a single 16-bit result.

Memory accesses, and all accesses in big-endian mode, are never split. The request, the control bits and the card's width indication are all captured when the request is accepted. Only one access is outstanding at a time.

Top module: `pcAddrXlate`

## Requirements
- R1: After reset the control register reads 0, `reqReady` is 1, and `cardCycle` and `doneValid` are 0.
- R2: Register bit 0 is the space bit (1 = common memory, 0 = attribute memory), bit 1 is the segment bit and bit 2 is the narrow-window bit. All three read back as written; bits 7..3 always read 0.
- R3: For a memory access, `cardAddr[24:0]` equals `reqOffset[24:0]`. When the space bit is 1, `cardAddr[25]` equals the segment bit.
- R4: For attribute-memory and I/O accesses, `cardAddr[25]` is 0 whatever the segment bit and `reqOffset[25]` hold.
- R5: During a memory access `cardSpaceSel` equals the space bit. During an I/O access it is 0 even when the space bit is 1.
- R6: With the narrow-window bit set, `cardAddr[24]` is 0 for attribute and I/O accesses. Common-memory addresses are unchanged by that bit.
- R7: An access that is not split is one card cycle. `cardCycle` stays high and `cardAddr` stays stable until `cardReady` is sampled high. In the next cycle `doneValid` is high for exactly one cycle, `cardCycle` is 0 and `reqReady` is 1. A 16-bit read returns `cardRData`; an 8-bit read returns `{8'h00, cardRData[7:0]}`.
- R8: An I/O access with `reqWide`=1, `reqLittle`=1 and `cardIs16`=0 at acceptance makes two card cycles, the first at the offset and the second at the offset plus one. Write bytes go out on `cardWData[7:0]`, low byte first. A read returns `{second cycle byte, first cycle byte}`, taken from `cardRData[7:0]`, with one `doneValid` pulse.
- R9: A 16-bit I/O access with `reqLittle`=0, or with `cardIs16`=1, is a single card cycle.
- R10: While an access is outstanding `reqReady` is 0 and a request presented then starts no cycle and does not change `cardAddr`.
- R11: A 16-bit memory access is a single card cycle even when `cardIs16` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read data |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block can accept a request |
| reqOffset | input | 26 | Offset inside the card window |
| reqIsIo | input | 1 | 1 = I/O space, 0 = memory space |
| reqWide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit |
| reqLittle | input | 1 | 1 = little-endian mode |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWData | input | 16 | Host write data |
| cardAddr | output | 26 | Card address lines |
| cardSpaceSel | output | 1 | Register-select pin level |
| cardCycle | output | 1 | A card cycle is in progress |
| cardWrite | output | 1 | Direction of the card cycle |
| cardWData | output | 16 | Card write data |
| cardRData | input | 16 | Card read data |
| cardReady | input | 1 | Card completes the current cycle |
| cardIs16 | input | 1 | Card reports a 16-bit port |
| doneValid | output | 1 | One-cycle completion pulse |
| doneRData | output | 16 | Read result, valid with `doneValid` |

## Verification
The address-increment check on the second byte cycle assumes that a 16-bit I/O offset is even, so that adding one never carries past bit 0. The bench therefore uses only even offsets for split accesses. The hold checks assume that `cardReady` is raised only while `cardCycle` is high. The bench's card model asserts it only after it has seen the cycle for at least one clock. No vector writes the register while an access is outstanding.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int CTRL_W     = 3;
  localparam int BIT_SPACE  = 0;
  localparam int BIT_SEG    = 1;
  localparam int BIT_NARROW = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } pcxState_t;

  typedef struct packed {
    logic load;
    logic phaseHi;
    logic capFirst;
    logic capSecond;
  } pcxStrobe_t;
endpackage

// File: rtl/pcxCtrl.sv
module pcxCtrl
  import pcx_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             splitReq,
  input  logic             cardReady,
  output logic             cardCycle,
  output logic             doneValid,
  output logic             spaceSel,
  output logic             segBit,
  output logic             narrowMode,
  output pcxStrobe_t       strobe
);
  localparam int PAD_W = REG_W - CTRL_W;

  pcxState_t        state, stateNext;
  logic [CTRL_W-1:0] ctrlQ;
  logic              doneQ;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          stateNext   = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (cardReady) begin
          strobe.capFirst = 1'b1;
          stateNext       = splitReq ? ST_SECOND : ST_IDLE;
        end
      end
      ST_SECOND: begin
        strobe.phaseHi = 1'b1;
        if (cardReady) begin
          strobe.capSecond = 1'b1;
          stateNext        = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ctrlQ <= '0;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= (state != ST_IDLE) && (stateNext == ST_IDLE);
      if (regWrEn) ctrlQ <= regWrData[CTRL_W-1:0];
    end
  end

  assign reqReady   = (state == ST_IDLE);
  assign cardCycle  = (state != ST_IDLE);
  assign doneValid  = doneQ;
  assign spaceSel   = ctrlQ[BIT_SPACE];
  assign segBit     = ctrlQ[BIT_SEG];
  assign narrowMode = ctrlQ[BIT_NARROW];
  assign regRdData  = {{PAD_W{1'b0}}, ctrlQ};

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);                                   // R7
  AST_DONE_FREES_HOST: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (reqReady && !cardCycle));                     // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (cardCycle && !cardReady) |=> cardCycle);                    // R10
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[REG_W-1:CTRL_W] == '0);                            // R2
endmodule

// File: rtl/pcxData.sv
module pcxData
  import pcx_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcxStrobe_t        strobe,
  input  logic              active,
  input  logic              cardReady,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic              reqIsIo,
  input  logic              reqWide,
  input  logic              reqLittle,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWData,
  input  logic              cardIs16,
  input  logic              spaceSel,
  input  logic              segBit,
  input  logic              narrowMode,
  input  logic [DATA_W-1:0] cardRData,
  output logic              splitReq,
  output logic [ADDR_W-1:0] cardAddr,
  output logic              cardSpaceSel,
  output logic              cardWrite,
  output logic [DATA_W-1:0] cardWData,
  output logic [DATA_W-1:0] doneRData
);
  localparam int LOW_W  = ADDR_W - 1;
  localparam int BYTE_W = DATA_W / 2;

  logic [ADDR_W-1:0] offQ;
  logic [DATA_W-1:0] wdQ, rdQ;
  logic              ioQ, wideQ, writeQ, splitQ, commonQ, segQ, narrowQ;
  logic [LOW_W-1:0]  lowAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offQ    <= '0;
      wdQ     <= '0;
      rdQ     <= '0;
      ioQ     <= 1'b0;
      wideQ   <= 1'b0;
      writeQ  <= 1'b0;
      splitQ  <= 1'b0;
      commonQ <= 1'b0;
      segQ    <= 1'b0;
      narrowQ <= 1'b0;
    end else begin
      if (strobe.load) begin
        offQ    <= reqOffset;
        wdQ     <= reqWData;
        ioQ     <= reqIsIo;
        wideQ   <= reqWide;
        writeQ  <= reqWrite;
        splitQ  <= reqIsIo && reqWide && reqLittle && !cardIs16;
        commonQ <= !reqIsIo && spaceSel;
        segQ    <= segBit;
        narrowQ <= narrowMode;
      end
      if (strobe.capFirst) begin
        if (splitQ)     rdQ[BYTE_W-1:0] <= cardRData[BYTE_W-1:0];
        else if (wideQ) rdQ <= cardRData;
        else            rdQ <= {{BYTE_W{1'b0}}, cardRData[BYTE_W-1:0]};
      end
      if (strobe.capSecond) rdQ[DATA_W-1:BYTE_W] <= cardRData[BYTE_W-1:0];
    end
  end

  always_comb begin
    lowAddr = offQ[LOW_W-1:0] + LOW_W'(strobe.phaseHi);
    if (narrowQ && !commonQ) lowAddr[LOW_W-1] = 1'b0;
  end

  assign cardAddr     = {commonQ & segQ, lowAddr};
  assign cardSpaceSel = commonQ;
  assign cardWrite    = writeQ;
  assign cardWData    = !splitQ ? wdQ :
                        {{BYTE_W{1'b0}}, strobe.phaseHi ? wdQ[DATA_W-1:BYTE_W] : wdQ[BYTE_W-1:0]};
  assign splitReq     = splitQ;
  assign doneRData    = rdQ;

  AST_IO_SEL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (active && ioQ) |-> !cardSpaceSel);                          // R5
  AST_TOP_LINE_NONCOMMON: assert property (@(posedge clk) disable iff (!rstN)
    (active && (ioQ || !cardSpaceSel)) |-> !cardAddr[ADDR_W-1]); // R4
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (active && !cardReady) |=> $stable(cardAddr));               // R7
  AST_SECOND_BYTE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.phaseHi) |->
      cardAddr[LOW_W-2:0] == $past(cardAddr[LOW_W-2:0]) + 1'b1); // R8
  AST_SPLIT_ONLY_IO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.phaseHi |-> ioQ);                                     // R11
endmodule

// File: rtl/pcAddrXlate.sv
module pcAddrXlate
  import pcx_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqOffset,
  input  logic              reqIsIo,
  input  logic              reqWide,
  input  logic              reqLittle,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWData,
  output logic [ADDR_W-1:0] cardAddr,
  output logic              cardSpaceSel,
  output logic              cardCycle,
  output logic              cardWrite,
  output logic [DATA_W-1:0] cardWData,
  input  logic [DATA_W-1:0] cardRData,
  input  logic              cardReady,
  input  logic              cardIs16,
  output logic              doneValid,
  output logic [DATA_W-1:0] doneRData
);
  pcxStrobe_t strobe;
  logic       splitReq, spaceSel, segBit, narrowMode;

  pcxCtrl #(.REG_W(REG_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .splitReq   (splitReq),
    .cardReady  (cardReady),
    .cardCycle  (cardCycle),
    .doneValid  (doneValid),
    .spaceSel   (spaceSel),
    .segBit     (segBit),
    .narrowMode (narrowMode),
    .strobe     (strobe)
  );

  pcxData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .active       (cardCycle),
    .cardReady    (cardReady),
    .reqOffset    (reqOffset),
    .reqIsIo      (reqIsIo),
    .reqWide      (reqWide),
    .reqLittle    (reqLittle),
    .reqWrite     (reqWrite),
    .reqWData     (reqWData),
    .cardIs16     (cardIs16),
    .spaceSel     (spaceSel),
    .segBit       (segBit),
    .narrowMode   (narrowMode),
    .cardRData    (cardRData),
    .splitReq     (splitReq),
    .cardAddr     (cardAddr),
    .cardSpaceSel (cardSpaceSel),
    .cardWrite    (cardWrite),
    .cardWData    (cardWData),
    .doneRData    (doneRData)
  );
endmodule

// File: tb/pcAddrXlate_tb_top.sv
`timescale 1ns/1ps
module pcAddrXlate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [25:0] reqOffset = '0;
  logic        reqIsIo = 1'b0, reqWide = 1'b0, reqLittle = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqWData = '0;
  logic [25:0] cardAddr;
  logic        cardSpaceSel, cardCycle, cardWrite;
  logic [15:0] cardWData;
  logic [15:0] cardRData = '0;
  logic        cardReady = 1'b0, cardIs16 = 1'b0;
  logic        doneValid;
  logic [15:0] doneRData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pcAddrXlate dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .reqValid(reqValid), .reqReady(reqReady),
    .reqOffset(reqOffset), .reqIsIo(reqIsIo), .reqWide(reqWide),
    .reqLittle(reqLittle), .reqWrite(reqWrite), .reqWData(reqWData),
    .cardAddr(cardAddr), .cardSpaceSel(cardSpaceSel), .cardCycle(cardCycle),
    .cardWrite(cardWrite), .cardWData(cardWData), .cardRData(cardRData),
    .cardReady(cardReady), .cardIs16(cardIs16), .doneValid(doneValid),
    .doneRData(doneRData)
  );

  typedef struct packed {
    logic [2:0]  ctl;
    logic        io, wide, little, is16, wr;
    logic [25:0] off;
    logic [25:0] expAddr;
    logic        expSel;
    logic [1:0]  expCyc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 26'h0123456, 26'h0123456, 1'b0, 2'd1},
    '{3'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 26'h01ABCDE, 26'h21ABCDE, 1'b1, 2'd1},
    '{3'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 26'h3FFFFFF, 26'h1FFFFFF, 1'b0, 2'd1},
    '{3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 26'h2000100, 26'h0000100, 1'b0, 2'd1},
    '{3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 26'h0000200, 26'h0000200, 1'b0, 2'd2},
    '{3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 26'h0000240, 26'h0000240, 1'b0, 2'd2},
    '{3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 26'h0000300, 26'h0000300, 1'b0, 2'd1},
    '{3'd4, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 26'h1800010, 26'h0800010, 1'b0, 2'd1},
    '{3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 26'h1800044, 26'h3800044, 1'b1, 2'd1}
  };
  string tags [NV] = '{"R3", "R3 R5", "R4", "R4 R5 R9", "R8", "R8",
                        "R9", "R6", "R6 R11"};

  function automatic logic [15:0] pat(input logic [25:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setReg(input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runVec(input vec_t v, input string tag);
    int nc;
    logic [25:0] a0, aNow;
    logic s0;
    logic [15:0] wd, expRd;
    wd = v.off[15:0] ^ 16'hC3D2;
    setReg({5'b0, v.ctl});
    reqOffset = v.off; reqIsIo = v.io; reqWide = v.wide; reqLittle = v.little;
    reqWrite = v.wr; reqWData = wd; cardIs16 = v.is16; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    nc = 0; a0 = '0; s0 = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (!cardCycle) break;
      aNow = cardAddr;
      if (nc == 0) begin a0 = aNow; s0 = cardSpaceSel; end
      else chk(aNow == a0 + 26'd1, {tag, " second addr"}, 32'(aNow), 32'(a0 + 26'd1));
      chk(cardWrite == v.wr, {tag, " direction"}, 32'(cardWrite), 32'(v.wr));
      if (v.wr) begin
        if (v.expCyc == 2'd2)
          chk(cardWData[7:0] == (nc == 0 ? wd[7:0] : wd[15:8]), {tag, " byte lane"},
              32'(cardWData[7:0]), 32'(nc == 0 ? wd[7:0] : wd[15:8]));
        else
          chk(cardWData == wd, {tag, " wdata"}, 32'(cardWData), 32'(wd));
      end
      @(negedge clk);
      chk(cardAddr == aNow && cardCycle, "R7 hold", 32'(cardAddr), 32'(aNow));
      cardReady = 1'b1; cardRData = pat(aNow);
      @(negedge clk);
      cardReady = 1'b0;
      nc++;
      if (doneValid) break;
    end
    chk(doneValid, {tag, " R7 done"}, 32'(doneValid), 32'd1);
    chk(nc == int'(v.expCyc), {tag, " cycles"}, 32'(nc), 32'(v.expCyc));
    chk(a0 == v.expAddr, {tag, " addr"}, 32'(a0), 32'(v.expAddr));
    chk(s0 == v.expSel, {tag, " regsel"}, 32'(s0), 32'(v.expSel));
    if (!v.wr) begin
      if (v.expCyc == 2'd2) expRd = {pat(v.expAddr + 26'd1)[7:0], pat(v.expAddr)[7:0]};
      else if (v.wide)      expRd = pat(v.expAddr);
      else                  expRd = {8'h00, pat(v.expAddr)[7:0]};
      chk(doneRData == expRd, {tag, " rdata"}, 32'(doneRData), 32'(expRd));
    end
    @(negedge clk);
    chk(!doneValid && reqReady && !cardCycle, "R7 single pulse",
        {29'd0, doneValid, reqReady, cardCycle}, 32'b010);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(regRdData == 8'h00, "R1 register", 32'(regRdData), 32'h0);
    chk(reqReady && !cardCycle && !doneValid, "R1 handshake",
        {29'd0, reqReady, cardCycle, doneValid}, 32'b100);

    // R2 readback and reserved bits
    setReg(8'hFF);
    chk(regRdData == 8'h07, "R2 readback ones", 32'(regRdData), 32'h07);
    setReg(8'h05);
    chk(regRdData == 8'h05, "R2 readback mixed", 32'(regRdData), 32'h05);

    for (int i = 0; i < NV; i++) runVec(VECS[i], tags[i]);

    // R10 request while busy is ignored
    setReg(8'h00);
    reqOffset = 26'h0000010; reqIsIo = 1'b0; reqWide = 1'b1; reqWrite = 1'b0;
    reqValid = 1'b1;
    @(negedge clk);
    reqOffset = 26'h0000099;
    chk(!reqReady && cardCycle, "R10 not ready", 32'(reqReady), 32'd0);
    @(negedge clk);
    chk(cardAddr == 26'h0000010, "R10 addr kept", 32'(cardAddr), 32'h10);
    reqValid = 1'b0; cardReady = 1'b1; cardRData = 16'h1234;
    @(negedge clk);
    cardReady = 1'b0;
    chk(doneValid && doneRData == 16'h1234, "R10 first completes",
        32'(doneRData), 32'h1234);
    @(negedge clk);
    chk(!cardCycle, "R10 no second cycle", 32'(cardCycle), 32'd0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule